// File: doc/BRIEF.md
# SIMD Lane Move and Merge Unit

This block is the data-movement slice of a vector execution pipeline. It owns a file of wide registers, each split into four 32-bit lanes, and each cycle it may carry out one move operation. A move copies a whole register, one scalar lane or one 64-bit half, either between two registers or between a register and memory. A separate operation gathers the top bit of every lane into a small mask on a general-purpose result bus.

Every move writes only its own target portion of the destination register, and the rest of that register keeps its old value. Because of this, the destination register is read on a second port and merged with the new data before the write. A full-width memory move comes in two forms. The checked form raises a one-cycle fault and does nothing when its address is not 16-byte aligned. The unchecked form accepts any address.

The memory port is single-cycle. Address, write data, byte enables and the strobes follow the operation inputs combinationally, and read data returns in the same cycle. The fault flag and the mask result are registered.

Top module: `simd_move_unit`

## Requirements
- R1: Lane i of a register is bits 32*i+31 down to 32*i. The full register move (code 1) copies all 128 bits from the source to the destination. The unchecked full load (code 3) writes mem_rdata[127:0] into the destination. The unchecked full store (code 5) drives mem_wdata with the source register and mem_be with 16'hFFFF. Neither unchecked form faults, whatever the address.
- R2: With ALIGN_CHECK=1, a checked full load (code 2) or checked full store (code 4) whose op_addr[3:0] is nonzero raises no memory request and writes no register. In the following cycle fault is high, and it drops again after one cycle unless another faulting operation follows.
- R3: A checked full load or store at an address with op_addr[3:0] zero behaves exactly like its unchecked form, and fault stays low.
- R4: The scalar register move (code 6) replaces destination lane 0 with source lane 0 and keeps destination lanes 1 to 3.
- R5: The scalar load (code 7) writes mem_rdata[31:0] into lane 0 and clears lanes 1 to 3. The scalar store (code 8) drives mem_be=16'h000F and mem_wdata[31:0] with source lane 0, and the other write-data bits are zero. Neither scalar form faults at any address.
- R6: The low-half load (code 9) writes mem_rdata[63:0] into destination bits 63:0 and keeps bits 127:64. The high-half load (code 10) writes mem_rdata[63:0] into bits 127:64 and keeps bits 63:0.
- R7: The low-half store (code 11) puts source bits 63:0 on mem_wdata[63:0]. The high-half store (code 12) puts source bits 127:64 on mem_wdata[63:0]. Both drive mem_be=16'h00FF, and the upper write-data bits are zero.
- R8: The low-to-high move (code 13) copies source bits 63:0 into destination bits 127:64 and keeps destination bits 63:0.
- R9: The high-to-low move (code 14) copies source bits 127:64 into destination bits 63:0 and keeps destination bits 127:64.
- R10: The sign-mask operation (code 15) makes gp_valid high for one cycle in the following cycle. In that cycle gp_result bit i equals source bit 32*i+31 and bits 31:4 are zero. The operation writes no register and makes no memory request.
- R11: A synchronous reset clears all registers, fault, gp_valid and gp_result.
- R12: Register-only operations and code 0 keep mem_req low. While op_valid is low, the block makes no memory request and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| op_dst | input | 3 | Destination register index |
| op_src | input | 3 | Source register index |
| op_addr | input | 32 | Memory byte address |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 16 | Byte enables, byte 0 on bits 7:0 |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, same cycle |
| fault | output | 1 | Alignment fault pulse |
| gp_valid | output | 1 | Sign mask result valid |
| gp_result | output | 32 | Sign mask result |

## Verification
The bench builds the block with its defaults: four 32-bit lanes, eight registers, a 32-bit address and ALIGN_CHECK=1. With alignment checking enabled, the fault path and its write suppression can be reached from both checked operations. With eight registers, the reference patterns stay live in some registers while others serve as merge destinations. The bench reads register contents back through unchecked full stores on the memory port. Its patterns mix set and clear lane sign bits, so that every half-preserving and lane-preserving merge gives a result that differs from both of its inputs.

// File: rtl/smov_pkg.sv
package smov_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_MOVR   = 4'd1,
    OP_LDA    = 4'd2,
    OP_LDU    = 4'd3,
    OP_STA    = 4'd4,
    OP_STU    = 4'd5,
    OP_MOVSR  = 4'd6,
    OP_LDS    = 4'd7,
    OP_STS    = 4'd8,
    OP_LDLO   = 4'd9,
    OP_LDHI   = 4'd10,
    OP_STLO   = 4'd11,
    OP_STHI   = 4'd12,
    OP_LO2HI  = 4'd13,
    OP_HI2LO  = 4'd14,
    OP_SGNMSK = 4'd15
  } smov_op_e;
endpackage

// File: rtl/smov_regfile.sv
module smov_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 128,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];

  // R1: a write is visible on the next cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/smov_merge.sv
module smov_merge
  import smov_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VW    = LANE_W * LANES,
  localparam int HALF  = VW / 2,
  localparam int NB    = VW / 8
) (
  input  logic            valid,
  input  smov_op_e        op,
  input  logic [VW-1:0]   dst_val,
  input  logic [VW-1:0]   src_val,
  input  logic [VW-1:0]   rdata,
  output logic            wr_en,
  output logic [VW-1:0]   wr_data,
  output logic            req,
  output logic            we,
  output logic [NB-1:0]   be,
  output logic [VW-1:0]   wdata,
  output logic            checked,
  output logic            mask_en,
  output logic [LANES-1:0] mask
);
  localparam logic [NB-1:0] BE_FULL = {NB{1'b1}};
  localparam logic [NB-1:0] BE_HALF = {{(NB - NB/2){1'b0}}, {(NB/2){1'b1}}};
  localparam int LB = LANE_W / 8;
  localparam logic [NB-1:0] BE_LANE = {{(NB - LB){1'b0}}, {LB{1'b1}}};

  for (genvar g = 0; g < LANES; g++) begin : g_sign
    assign mask[g] = src_val[g*LANE_W + LANE_W - 1];
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_data = dst_val;
    req     = 1'b0;
    we      = 1'b0;
    be      = '0;
    wdata   = '0;
    checked = 1'b0;
    mask_en = 1'b0;
    if (valid) begin
      unique case (op)
        OP_MOVR: begin
          wr_en   = 1'b1;
          wr_data = src_val;
        end
        OP_LDA, OP_LDU: begin
          wr_en   = 1'b1;
          wr_data = rdata;
          req     = 1'b1;
          checked = (op == OP_LDA);
        end
        OP_STA, OP_STU: begin
          req     = 1'b1;
          we      = 1'b1;
          be      = BE_FULL;
          wdata   = src_val;
          checked = (op == OP_STA);
        end
        OP_MOVSR: begin
          wr_en = 1'b1;
          wr_data[LANE_W-1:0] = src_val[LANE_W-1:0];
        end
        OP_LDS: begin
          wr_en   = 1'b1;
          req     = 1'b1;
          wr_data = '0;
          wr_data[LANE_W-1:0] = rdata[LANE_W-1:0];
        end
        OP_STS: begin
          req = 1'b1;
          we  = 1'b1;
          be  = BE_LANE;
          wdata[LANE_W-1:0] = src_val[LANE_W-1:0];
        end
        OP_LDLO: begin
          wr_en = 1'b1;
          req   = 1'b1;
          wr_data[HALF-1:0] = rdata[HALF-1:0];
        end
        OP_LDHI: begin
          wr_en = 1'b1;
          req   = 1'b1;
          wr_data[VW-1:HALF] = rdata[HALF-1:0];
        end
        OP_STLO: begin
          req = 1'b1;
          we  = 1'b1;
          be  = BE_HALF;
          wdata[HALF-1:0] = src_val[HALF-1:0];
        end
        OP_STHI: begin
          req = 1'b1;
          we  = 1'b1;
          be  = BE_HALF;
          wdata[HALF-1:0] = src_val[VW-1:HALF];
        end
        OP_LO2HI: begin
          wr_en = 1'b1;
          wr_data[VW-1:HALF] = src_val[HALF-1:0];
        end
        OP_HI2LO: begin
          wr_en = 1'b1;
          wr_data[HALF-1:0] = src_val[VW-1:HALF];
        end
        OP_SGNMSK: mask_en = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simd_move_unit.sv
module simd_move_unit
  import smov_pkg::*;
#(
  parameter int LANE_W      = 32,
  parameter int LANES       = 4,
  parameter int NREG        = 8,
  parameter int AW          = 32,
  parameter int GP_W        = 32,
  parameter bit ALIGN_CHECK = 1'b1,
  localparam int VW         = LANE_W * LANES,
  localparam int NB         = VW / 8,
  localparam int IW         = $clog2(NREG),
  localparam int ABITS      = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [IW-1:0] op_dst,
  input  logic [IW-1:0] op_src,
  input  logic [AW-1:0] op_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [NB-1:0] mem_be,
  output logic [VW-1:0] mem_wdata,
  input  logic [VW-1:0] mem_rdata,
  output logic          fault,
  output logic          gp_valid,
  output logic [GP_W-1:0] gp_result
);
  localparam int HALF = VW / 2;

  logic [VW-1:0]    dst_val, src_val, rf_wdata, raw_wdata;
  logic             raw_wr, raw_req, raw_we, checked, mask_en, misaligned, rf_we;
  logic [NB-1:0]    raw_be;
  logic [LANES-1:0] mask;

  smov_regfile #(.NREG(NREG), .DW(VW)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(op_dst), .wdata(rf_wdata),
    .ra_addr(op_dst), .ra_data(dst_val),
    .rb_addr(op_src), .rb_data(src_val)
  );

  smov_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
    .valid(op_valid), .op(smov_op_e'(op_code)),
    .dst_val(dst_val), .src_val(src_val), .rdata(mem_rdata),
    .wr_en(raw_wr), .wr_data(rf_wdata),
    .req(raw_req), .we(raw_we), .be(raw_be), .wdata(raw_wdata),
    .checked(checked), .mask_en(mask_en), .mask(mask)
  );

  assign misaligned = ALIGN_CHECK && checked && (op_addr[ABITS-1:0] != '0);
  assign rf_we      = raw_wr  && !misaligned;
  assign mem_req    = raw_req && !misaligned;
  assign mem_we     = raw_we  && !misaligned;
  assign mem_be     = misaligned ? '0 : raw_be;
  assign mem_wdata  = raw_wdata;
  assign mem_addr   = op_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault     <= 1'b0;
      gp_valid  <= 1'b0;
      gp_result <= '0;
    end else begin
      fault    <= misaligned;
      gp_valid <= mask_en;
      if (mask_en) gp_result <= GP_W'(mask);
    end
  end

  // R2: a misaligned checked move makes no access and no write
  p_misalign_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (ALIGN_CHECK && op_valid && (op_code == OP_LDA || op_code == OP_STA) &&
     op_addr[ABITS-1:0] != '0) |-> (!mem_req && !rf_we));

  // R2: the fault flag follows a misaligned checked move
  p_fault_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (ALIGN_CHECK && op_valid && (op_code == OP_LDA || op_code == OP_STA) &&
     op_addr[ABITS-1:0] != '0) |=> fault);

  // R12: no operation writes a register and memory at once
  p_single_target_r12: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && mem_we));

  // R6: low-half load keeps the upper half of the destination
  p_lo_load_keeps_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_LDLO) |-> (rf_wdata[VW-1:HALF] == dst_val[VW-1:HALF]));

  // R9: high-to-low move keeps the upper half of the destination
  p_hi2lo_keeps_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_HI2LO) |-> (rf_wdata[VW-1:HALF] == dst_val[VW-1:HALF]));

  // R5: scalar store enables only the low lane bytes
  p_scalar_be_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_STS) |-> (mem_req && $countones(mem_be) == LANE_W/8 && mem_be[0]));

  // R10: the mask result is a single-cycle pulse per operation
  p_gp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    gp_valid |-> $past(op_valid && op_code == OP_SGNMSK));
endmodule

// File: tb/tb_simd_move_unit.sv
`timescale 1ns/1ps
module tb_simd_move_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [2:0]   op_dst = '0, op_src = '0;
  logic [31:0]  op_addr = '0;
  logic         mem_req, mem_we, fault, gp_valid;
  logic [31:0]  mem_addr, gp_result;
  logic [15:0]  mem_be;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic         c_req, c_we, s_fault, s_gpv;
  logic [15:0]  c_be;
  logic [127:0] c_wdata;
  logic [31:0]  s_gp;

  localparam logic [127:0] V1 = 128'h80000001_7FFF0002_FFFF0003_00000004;
  localparam logic [127:0] V2 = 128'h11111111_22222222_33333333_44444444;

  always #2 clk = ~clk;

  simd_move_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_dst(op_dst), .op_src(op_src), .op_addr(op_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fault(fault), .gp_valid(gp_valid), .gp_result(gp_result)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input bit v, input logic [3:0] code, input logic [2:0] d,
                     input logic [2:0] s, input logic [31:0] a, input logic [127:0] rd);
    @(negedge clk);
    op_valid = v; op_code = code; op_dst = d; op_src = s; op_addr = a; mem_rdata = rd;
    #1;
    c_req = mem_req; c_we = mem_we; c_be = mem_be; c_wdata = mem_wdata;
    @(posedge clk);
    #1;
    s_fault = fault; s_gpv = gp_valid; s_gp = gp_result;
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0;
  endtask

  task automatic peek(input logic [2:0] r, output logic [127:0] val);
    run(1'b1, 4'd5, 3'd0, r, 32'h0, '0);
    val = c_wdata;
  endtask

  task automatic t_reset();
    logic [127:0] v;
    chk("R11 fault", fault, 0);
    chk("R11 gp_valid", gp_valid, 0);
    chk("R11 gp_result", gp_result, 0);
    for (int r = 0; r < 8; r++) begin
      peek(3'(r), v);
      chk("R11 reg clear", v, '0);
    end
  endtask

  task automatic t_full();
    logic [127:0] v;
    run(1'b1, 4'd3, 3'd1, 3'd0, 32'h3, V1);
    chk("R1 unchecked load req", {c_req, c_we}, 2'b10);
    chk("R1 unchecked load no fault", s_fault, 0);
    peek(3'd1, v);
    chk("R1 unchecked load data", v, V1);
    chk("R1 unchecked store be", c_be, 16'hFFFF);
    run(1'b1, 4'd1, 3'd3, 3'd1, 32'h0, '0);
    chk("R12 reg move no mem", c_req, 0);
    peek(3'd3, v);
    chk("R1 full reg move", v, V1);
  endtask

  task automatic t_aligned();
    logic [127:0] v;
    run(1'b1, 4'd2, 3'd2, 3'd0, 32'h10, V2);
    chk("R3 aligned load no fault", s_fault, 0);
    peek(3'd2, v);
    chk("R3 aligned load data", v, V2);
    run(1'b1, 4'd4, 3'd0, 3'd2, 32'h20, '0);
    chk("R3 aligned store strobes", {c_req, c_we, c_be}, {2'b11, 16'hFFFF});
    chk("R3 aligned store data", c_wdata, V2);
  endtask

  task automatic t_fault();
    logic [127:0] v;
    run(1'b1, 4'd2, 3'd2, 3'd0, 32'h14, V1);
    chk("R2 load fault no req", c_req, 0);
    chk("R2 load fault flag", s_fault, 1);
    run(1'b0, 4'd0, 3'd0, 3'd0, 32'h0, '0);
    chk("R2 fault one cycle", s_fault, 0);
    peek(3'd2, v);
    chk("R2 dest unchanged", v, V2);
    run(1'b1, 4'd4, 3'd0, 3'd1, 32'h21, '0);
    chk("R2 store fault no write", {c_req, c_we}, 2'b00);
    chk("R2 store fault flag", s_fault, 1);
  endtask

  task automatic t_scalar();
    logic [127:0] v;
    run(1'b1, 4'd6, 3'd2, 3'd1, 32'h0, '0);
    peek(3'd2, v);
    chk("R4 scalar reg move", v, {V2[127:32], V1[31:0]});
    run(1'b1, 4'd7, 3'd4, 3'd0, 32'h7, V2);
    chk("R5 scalar load no fault", s_fault, 0);
    peek(3'd4, v);
    chk("R5 scalar load clears", v, {96'h0, V2[31:0]});
    run(1'b1, 4'd8, 3'd0, 3'd1, 32'h5, '0);
    chk("R5 scalar store be", c_be, 16'h000F);
    chk("R5 scalar store data", c_wdata, {96'h0, V1[31:0]});
  endtask

  task automatic t_half();
    logic [127:0] v;
    run(1'b1, 4'd3, 3'd2, 3'd0, 32'h0, V2);
    run(1'b1, 4'd9, 3'd2, 3'd0, 32'h8, V1);
    peek(3'd2, v);
    chk("R6 low half load", v, {V2[127:64], V1[63:0]});
    run(1'b1, 4'd10, 3'd3, 3'd0, 32'h8, V2);
    peek(3'd3, v);
    chk("R6 high half load", v, {V2[63:0], V1[63:0]});
    run(1'b1, 4'd11, 3'd0, 3'd1, 32'h9, '0);
    chk("R7 low store be", c_be, 16'h00FF);
    chk("R7 low store data", c_wdata, {64'h0, V1[63:0]});
    run(1'b1, 4'd12, 3'd0, 3'd1, 32'h9, '0);
    chk("R7 high store data", c_wdata, {64'h0, V1[127:64]});
  endtask

  task automatic t_swap();
    logic [127:0] v;
    run(1'b1, 4'd3, 3'd5, 3'd0, 32'h0, V2);
    run(1'b1, 4'd13, 3'd5, 3'd1, 32'h0, '0);
    chk("R8 no mem", c_req, 0);
    peek(3'd5, v);
    chk("R8 low to high", v, {V1[63:0], V2[63:0]});
    run(1'b1, 4'd3, 3'd6, 3'd0, 32'h0, V2);
    run(1'b1, 4'd14, 3'd6, 3'd1, 32'h0, '0);
    peek(3'd6, v);
    chk("R9 high to low", v, {V2[127:64], V1[127:64]});
  endtask

  task automatic t_mask();
    run(1'b1, 4'd15, 3'd0, 3'd1, 32'h0, '0);
    chk("R10 mask no mem", c_req, 0);
    chk("R10 mask valid", s_gpv, 1);
    chk("R10 mask value", s_gp, 32'hA);
    run(1'b0, 4'd0, 3'd0, 3'd0, 32'h0, '0);
    chk("R10 mask pulse", s_gpv, 0);
    run(1'b1, 4'd15, 3'd0, 3'd6, 32'h0, '0);
    chk("R10 mask second", s_gp, 32'h2);
  endtask

  task automatic t_idle();
    logic [127:0] v;
    run(1'b0, 4'd3, 3'd1, 3'd0, 32'h0, V2);
    chk("R12 idle no req", c_req, 0);
    peek(3'd1, v);
    chk("R12 idle no write", v, V1);
    run(1'b1, 4'd0, 3'd1, 3'd0, 32'h0, V2);
    chk("R12 nop no req", c_req, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_aligned();
    t_fault();
    t_scalar();
    t_half();
    t_swap();
    t_mask();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule